// File: doc/BRIEF.md
# Entropy Collection Controller

This block turns a free-running raw entropy bit (standing in for a ring oscillator) into words that software can read over a simple APB-like register port. Software programs a decimation period and a collection length. It then sets the start flag. The block captures one raw bit per period and shifts it into the output word store until the requested number of bits has been gathered. It then drops the start flag, which software polls as a busy indication.

The control register accepts masked writes: the upper half of the write data selects which lower-half bits are updated, so single fields can be changed without a read-modify-write. The oscillator speed field is only held and driven to the `osc_speed` output. A separate clear register wipes the sampling state and the output words.

Top module: `entropy_collector`

## Requirements
- R1: After reset, every mapped register reads zero and `osc_speed` is 0.
- R2: A write to the control register (offset 0x400) changes a control bit in [5:0] only when bit 16+i of the write data is set. The bit then takes data bit i. Bits are: [5:4] length code, [3:2] oscillator speed (driven on `osc_speed`), [1] enable, [0] start. The control register's other bits read zero.
- R3: The sample-period register at offset 0x404 holds a 16-bit value that reads back zero-extended.
- R4: With enable set, a start written at clock edge W ends at edge W + N*P. N is 64*(length code + 1) bits and P is the effective period. Start reads 1 after edge W+N*P-1 and 0 after edge W+N*P.
- R5: The j-th capture (j = 1..N) takes the raw bit present at edge W + j*P. Bit k of the run is shifted into output word k/32 from the LSB side, so the earliest bit of each word ends at its most significant position.
- R6: If start is set while enable is 0, no bit is captured and start reads 0 one clock edge later.
- R7: Clearing enable during a collection leaves start set for one more edge, after which start reads 0.
- R8: A sample-period value of 0 behaves as 1, so one bit is captured on every edge.
- R9: Output words beyond the selected length keep their previous contents through a run.
- R10: Writing 1 to bit 0 of the clear register (offset 0x004) zeroes all output words and the sampling state and drops start. The register itself reads zero.
- R11: Reads of unmapped or misaligned addresses return zero, and writes to them change no register.
- R12: Writing 0xFFFF0000 to the control register clears every control bit, which stops the generator and returns `osc_speed` to 0.
- R13: Output word i (i = 0..7) reads at offset 0x410 + 4*i with its bytes reversed: bits [7:0] of the stored word appear at [31:24] of the read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase; a write commits when psel, penable and pwrite are high |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| raw_bit | input | 1 | Raw entropy bit |
| osc_speed | output | 2 | Stored oscillator speed field |

## Verification
Read data is combinational, so a register write committed at edge W is visible at the next falling edge. Start clears by itself one edge after being set with enable low, and one edge after enable is removed mid-run. A run of N bits at period P ends exactly at edge W+N*P. The bench counts rising edges and records the edge of each write. It drives the raw bit as a hash of the upcoming edge number, so each captured bit is known in advance. It samples start at edges W+N*P-1 and W+N*P, always on the falling edge.

// File: rtl/ecc_pkg.sv
// Shared types, register offsets and helpers for the entropy collection controller.
package ecc_pkg;

    localparam int ECC_AW = 12;
    localparam logic [ECC_AW-1:0] OFF_CLEAR = 12'h004;
    localparam logic [ECC_AW-1:0] OFF_CTRL  = 12'h400;
    localparam logic [ECC_AW-1:0] OFF_SCNT  = 12'h404;
    localparam logic [ECC_AW-1:0] OFF_WORD0 = 12'h410;
    localparam int CTRL_BITS = 6;

    // Control field layout: bits [5:4] length, [3:2] speed, [1] enable, [0] start.
    typedef struct packed {
        logic [1:0] len;
        logic [1:0] speed;
        logic       enable;
        logic       start;
    } ecc_ctrl_t;

    // Reverse the byte order of a 32-bit word.
    function automatic logic [31:0] ecc_bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/ecc_ctrl.sv
// Control register with high-half write mask and self-clearing start flag.
// Assumes wr is a one-cycle commit strobe. A hardware clear of start
// (done, clear pulse, start without enable) wins over a same-cycle write.
module ecc_ctrl
    import ecc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [CTRL_BITS-1:0] wval,
    input  logic [CTRL_BITS-1:0] wmask,
    input  logic                 clr,
    input  logic                 done,
    output ecc_ctrl_t            ctrl_q
);

    ecc_ctrl_t nxt;

    // Next value: masked merge of write data, then hardware clears of start.
    always_comb begin
        nxt = ctrl_q;
        if (wr) begin
            nxt = ecc_ctrl_t'((CTRL_BITS'(ctrl_q) & ~wmask) | (wval & wmask));
        end
        if (clr || done || (ctrl_q.start && !ctrl_q.enable)) begin
            nxt.start = 1'b0;
        end
    end

    // Register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= nxt;
        end
    end

endmodule

// File: rtl/ecc_sampler.sv
// Decimation timer and bit counter. While collect is high it raises capture
// once every max(smp_cnt,1) cycles and counts captured bits; done marks the
// capture that completes (len+1)*CHUNK_BITS bits. State resets whenever
// collect is low or clr pulses.
module ecc_sampler #(
    parameter int SCNT_W     = 16,
    parameter int CHUNK_BITS = 64,
    parameter int NWORDS     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      collect,
    input  logic [SCNT_W-1:0]         smp_cnt,
    input  logic [1:0]                len,
    output logic                      capture,
    output logic                      done,
    output logic [$clog2(NWORDS)-1:0] widx
);

    localparam int TOTAL = NWORDS * 32;
    localparam int NB_W  = $clog2(TOTAL) + 1;
    localparam int IDX_W = $clog2(NWORDS);

    logic [SCNT_W-1:0] cnt_q;
    logic [SCNT_W-1:0] period;
    logic [NB_W-1:0]   nbits_q;
    logic [NB_W-1:0]   target;

    // Effective period (zero treated as one) and requested bit count.
    always_comb begin
        period  = (smp_cnt == '0) ? SCNT_W'(1) : smp_cnt;
        target  = NB_W'((int'(len) + 1) * CHUNK_BITS);
        capture = collect && (cnt_q >= period - SCNT_W'(1));
        done    = capture && (nbits_q >= target - NB_W'(1));
        widx    = nbits_q[5 +: IDX_W];
    end

    // Period counter and captured-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !collect) begin
            cnt_q   <= '0;
            nbits_q <= '0;
        end else if (capture) begin
            cnt_q   <= '0;
            nbits_q <= nbits_q + NB_W'(1);
        end else begin
            cnt_q   <= cnt_q + SCNT_W'(1);
        end
    end

endmodule

// File: rtl/ecc_store.sv
// Output word store. On capture the raw bit is shifted into the LSB of the
// selected word; other words hold. clr zeroes every word.
module ecc_store #(
    parameter int NWORDS = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      capture,
    input  logic [$clog2(NWORDS)-1:0] widx,
    input  logic                      raw_bit,
    output logic [NWORDS-1:0][31:0]   words
);

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        // Shift register for word i.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                words[i] <= '0;
            end else if (capture && (int'(widx) == i)) begin
                words[i] <= {words[i][30:0], raw_bit};
            end
        end
    end

endmodule

// File: rtl/entropy_collector.sv
// Top: register decode, sample-period register and read mux around the
// control, sampler and store blocks. Assumes a write commits on one edge
// with psel, penable and pwrite high; reads are combinational on paddr.
module entropy_collector
    import ecc_pkg::*;
#(
    parameter int SCNT_W     = 16,
    parameter int NWORDS     = 8,
    parameter int CHUNK_BITS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ECC_AW-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic              raw_bit,
    output logic [1:0]        osc_speed
);

    localparam int IDX_W = $clog2(NWORDS);

    logic                    wr_en, wr_ctrl, wr_scnt, clr_pulse;
    logic [SCNT_W-1:0]       smp_cnt_q;
    ecc_ctrl_t               ctrl_q;
    logic                    capture, done, collect;
    logic [IDX_W-1:0]        widx;
    logic [NWORDS-1:0][31:0] words;
    logic [ECC_AW-1:0]       woff;
    logic                    word_hit;
    logic [31:0]             wdata_unused;

    // Write strobes per register.
    always_comb begin
        wr_en        = psel && penable && pwrite;
        wr_ctrl      = wr_en && (paddr == OFF_CTRL);
        wr_scnt      = wr_en && (paddr == OFF_SCNT);
        clr_pulse    = wr_en && (paddr == OFF_CLEAR) && pwdata[0];
        collect      = ctrl_q.start && ctrl_q.enable;
        osc_speed    = ctrl_q.speed;
        wdata_unused = pwdata;
    end

    // Sample-period register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_cnt_q <= '0;
        end else if (wr_scnt) begin
            smp_cnt_q <= pwdata[SCNT_W-1:0];
        end
    end

    ecc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_ctrl),
        .wval   (pwdata[CTRL_BITS-1:0]),
        .wmask  (pwdata[16 +: CTRL_BITS]),
        .clr    (clr_pulse),
        .done   (done),
        .ctrl_q (ctrl_q)
    );

    ecc_sampler #(
        .SCNT_W     (SCNT_W),
        .CHUNK_BITS (CHUNK_BITS),
        .NWORDS     (NWORDS)
    ) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_pulse),
        .collect (collect),
        .smp_cnt (smp_cnt_q),
        .len     (ctrl_q.len),
        .capture (capture),
        .done    (done),
        .widx    (widx)
    );

    ecc_store #(
        .NWORDS (NWORDS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_pulse),
        .capture (capture),
        .widx    (widx),
        .raw_bit (raw_bit),
        .words   (words)
    );

    // Read mux; unmapped and misaligned addresses return zero.
    always_comb begin
        woff     = paddr - OFF_WORD0;
        word_hit = (paddr >= OFF_WORD0) && (woff < ECC_AW'(NWORDS * 4)) && (paddr[1:0] == 2'b00);
        prdata   = '0;
        if (paddr == OFF_CTRL) begin
            prdata = {{(32-CTRL_BITS){1'b0}}, ctrl_q};
        end else if (paddr == OFF_SCNT) begin
            prdata = {{(32-SCNT_W){1'b0}}, smp_cnt_q};
        end else if (word_hit) begin
            prdata = ecc_bswap(words[woff[2 +: IDX_W]]);
        end
    end

endmodule

// File: rtl/ecc_chk.sv
// Checker for entropy_collector, attached with bind below.
module ecc_chk #(
    parameter int SCNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              enable,
    input logic [1:0]        osc_speed,
    input logic              wr_ctrl,
    input logic              wr_scnt,
    input logic              clr_pulse,
    input logic              capture,
    input logic              done,
    input logic [SCNT_W-1:0] smp_cnt
);

    // R6
    start_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !enable) |=> !start);

    // R2
    speed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(osc_speed));

    // R10
    clear_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pulse |=> !start);

    // R4
    done_drops_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !start);

    // R5
    decimate_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && (smp_cnt > SCNT_W'(1)) && !wr_scnt) |=> !capture);

    // R4
    capture_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> (start && enable));

endmodule

bind entropy_collector ecc_chk #(.SCNT_W(SCNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ctrl_q.start),
    .enable    (ctrl_q.enable),
    .osc_speed (osc_speed),
    .wr_ctrl   (wr_ctrl),
    .wr_scnt   (wr_scnt),
    .clr_pulse (clr_pulse),
    .capture   (capture),
    .done      (done),
    .smp_cnt   (smp_cnt_q)
);

// File: tb/tb_entropy_collector.sv
`timescale 1ns/1ps
module tb_entropy_collector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        raw_bit = 1'b0;
    logic [1:0]  osc_speed;

    int tests = 0;
    int fails = 0;
    int ecount = 0;
    int last_w = 0;
    int salt = 0;
    logic [31:0] exp_w [8];
    logic [5:0]  exp_ctrl = '0;

    entropy_collector dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .raw_bit(raw_bit),
        .osc_speed(osc_speed)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) ecount <= ecount + 1;

    // Raw bit for rising edge number t.
    function automatic logic raw_of(int t, int s);
        logic [31:0] h;
        h = (32'(t) * 32'h9E3779B1) ^ 32'(s);
        h = h ^ (h >> 15);
        return h[7];
    endfunction

    function automatic logic [31:0] bswap(logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    always @(negedge clk) raw_bit <= raw_of(ecount + 1, salt);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write committed at the next rising edge; returns at the falling edge after it.
    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        psel = 1; penable = 1; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        last_w = ecount;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        psel = 1; penable = 1; pwrite = 0; paddr = a;
        #0.5;
        d = prdata;
        psel = 0; penable = 0;
    endtask

    task automatic wait_edge(int e);
        while (ecount < e) @(negedge clk);
    endtask

    task automatic check_words(string req);
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(12'h410 + 12'(4 * i), d);
            check(req, d, bswap(exp_w[i]));
        end
    endtask

    // One collection run with full-mask control write.
    task automatic run(int len, int sc, int s);
        logic [31:0] d;
        int p, n, e;
        logic [1:0] spd;
        spd = 2'($urandom);
        wr(12'h404, 32'(sc));
        salt = s;
        p = (sc == 0) ? 1 : sc;
        n = 64 * (len + 1);
        wr(12'h400, {16'h003F, 10'd0, 2'(len), spd, 2'b11});
        exp_ctrl = {2'(len), spd, 2'b11};
        e = last_w + n * p;
        wait_edge(e - 1);
        rd(12'h400, d);
        check("R4 start still set", {31'd0, d[0]}, 32'd1);
        wait_edge(e);
        rd(12'h400, d);
        check("R4 start cleared at end", {31'd0, d[0]}, 32'd0);
        check("R2 osc_speed driven", {30'd0, osc_speed}, {30'd0, spd});
        exp_ctrl[0] = 1'b0;
        for (int k = 0; k < n; k++) begin
            exp_w[k / 32] = {exp_w[k / 32][30:0], raw_of(last_w + (k + 1) * p, s)};
        end
        check_words((sc == 0) ? "R8 R5 R13 R9 words" : "R5 R13 R9 words");
    endtask

    initial begin
        logic [31:0] d, m, v;
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) exp_w[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        rd(12'h400, d); check("R1 ctrl", d, 0);
        rd(12'h404, d); check("R1 scnt", d, 0);
        rd(12'h004, d); check("R1 clear reg", d, 0);
        check("R1 osc_speed", {30'd0, osc_speed}, 0);
        check_words("R1 words");

        // R3 sample-period register
        v = $urandom;
        wr(12'h404, v);
        rd(12'h404, d); check("R3 scnt readback", d, {16'd0, v[15:0]});

        // R2 random masked writes, start bit kept out of the mask
        for (int i = 0; i < 10; i++) begin
            m = $urandom & 32'h003E;
            v = $urandom & 32'h003E;
            wr(12'h400, {m[15:0], v[15:0]});
            exp_ctrl = (exp_ctrl & ~m[5:0]) | (v[5:0] & m[5:0]);
            rd(12'h400, d); check("R2 masked write", d, {26'd0, exp_ctrl});
            check("R2 osc_speed", {30'd0, osc_speed}, {30'd0, exp_ctrl[3:2]});
        end

        // R12 stop under full mask
        wr(12'h400, 32'hFFFF_0000);
        exp_ctrl = '0;
        rd(12'h400, d); check("R12 ctrl cleared", d, 0);
        check("R12 osc_speed", {30'd0, osc_speed}, 0);

        // R6 start without enable
        wr(12'h400, 32'h003F_0031);
        rd(12'h400, d); check("R6 start seen", d, 32'h31);
        @(negedge clk);
        rd(12'h400, d); check("R6 start self-cleared", d, 32'h30);
        check_words("R6 no capture");

        // Directed runs: period zero, longest then shortest, then random
        run(3, 0, 11);
        run(0, 3, 22);
        run(1, 1, 33);
        for (int i = 0; i < 6; i++) run(int'($urandom_range(0, 3)), int'($urandom_range(0, 4)), int'($urandom));

        // R7 abort by clearing enable
        wr(12'h404, 32'd2);
        wr(12'h400, 32'h003F_0033);
        repeat (20) @(negedge clk);
        wr(12'h400, 32'h0002_0000);
        rd(12'h400, d); check("R7 start one more edge", d, 32'h31);
        @(negedge clk);
        rd(12'h400, d); check("R7 start dropped", d, 32'h30);

        // R10 clear register
        wr(12'h004, 32'h1);
        for (int i = 0; i < 8; i++) exp_w[i] = '0;
        check_words("R10 words zero");
        rd(12'h004, d); check("R10 clear reads zero", d, 0);
        wr(12'h400, 32'h003F_0033);
        wr(12'h004, 32'h1);
        rd(12'h400, d); check("R10 start dropped", {31'd0, d[0]}, 0);
        wr(12'h400, 32'hFFFF_0000);
        run(0, 1, 44);

        // R11 unmapped and misaligned
        wr(12'h404, 32'd5);
        wr(12'h408, 32'hFFFF_FFFF);
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h401, 32'hFFFF_FFFF);
        rd(12'h408, d); check("R11 unmapped read", d, 0);
        rd(12'h412, d); check("R11 misaligned read", d, 0);
        rd(12'h430, d); check("R11 past words", d, 0);
        rd(12'h404, d); check("R11 scnt untouched", d, 5);
        rd(12'h400, d); check("R11 ctrl untouched", d, {26'd0, exp_ctrl});
        check_words("R11 words untouched");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule